// File: doc/BRIEF.md
# Random-Spaced Picket Generator

This block draws the fence pickets beside a scrolling race track so that the gaps between them look irregular. A trigger pulse that arrives at fixed intervals along the track fires a loadable one-shot timer. The timer output is the picket video bit. How long it stays high, in pixel-enable ticks, depends on the sum of the current track position and a 4-bit random word. Each picket therefore lands at a different offset.

The random word is held unchanged while its picket is still visible. A small position tracker follows the newest picket as it scrolls left. When the picket passes the left edge of the active area, the tracker raises a one-cycle reload strobe. On that strobe the word takes the low bits of a 16-bit LFSR, which advances once per video line. Until the next refresh, every picket reuses the same word.

Top module: `picket_gen`

## Requirements
- R1: The reset input is asynchronous and active low, and its release is synchronised to the clock. After reset, `picket` is 0, the random word is 0 and the LFSR holds the seed 16'hACE1.
- R2: A `trig` pulse sets `picket` on the next edge. The one-shot loads 15 minus ((word + track_pos) mod 16). It counts up by one on each `pix_en` and clears `picket` on the tick it leaves 15. `picket` is therefore high for ((word + track_pos) mod 16) + 1 pixel-enable ticks.
- R3: While `pix_en` is low, a running one-shot does not advance and `picket` stays high.
- R4: A `trig` that arrives while the one-shot is running restarts it with the load value computed from the current track position. `trig` takes priority over `pix_en` in the same cycle.
- R5: The track position enters the load value as a 4-bit sum that wraps. For example, with word 0 and track_pos 15 the picket is 16 ticks long.
- R6: The random word does not change while the picket it belongs to is on screen, even when the LFSR steps.
- R7: A `trig` places the picket at the right edge (X_RIGHT) and marks it on screen. Each `scroll` pulse moves an on-screen picket one step left. The scroll pulse that finds it at X_LEFT takes it off screen and raises a one-cycle reload strobe. On the following edge the word takes the LFSR's low 4 bits at that moment.
- R8: A `trig` while a picket is still on screen puts the position back at X_RIGHT, so X_RIGHT−X_LEFT+1 scroll pulses are needed again before the next reload.
- R9: `scroll` pulses while no picket is on screen have no effect: no reload strobe is raised and the word is unchanged.
- R10: The LFSR shifts right as a Galois register. When the bit shifted out is 1, the mask 16'hB400 is XORed into the state. The LFSR steps only in cycles where `line_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel enable; advances the one-shot |
| trig | input | 1 | Picket trigger pulse from the track |
| scroll | input | 1 | One-step leftward scroll of the track |
| line_tick | input | 1 | Once-per-line step for the LFSR |
| track_pos | input | WORD_W | Current track position code |
| picket | output | 1 | Picket-line video bit |

## Verification
The bench fires single pickets with track positions 0, 5 and 15. These show that the width follows the wrapped sum and the full 1-to-16 range. It also fires pickets after LFSR steps while a picket is on screen, which separates a word held until the picket leaves from one that tracks the LFSR live. A mid-run retrigger tells a restarting one-shot apart from one that ignores the trigger. Scroll counts one short of the exit, a retrigger part-way through, and extra scroll pulses off screen show that the reload happens exactly at the left edge, only once per picket, and takes the LFSR value of the strobe cycle rather than a later one.

// File: rtl/picket_pkg.sv
package picket_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t DEF_TAPS = 16'hB400;
  localparam lfsr_t DEF_SEED = 16'hACE1;
  typedef enum logic {TRK_OFF = 1'b0, TRK_ON = 1'b1} trk_state_e;
endpackage

// File: rtl/picket_lfsr.sv
module picket_lfsr
  import picket_pkg::*;
#(
  parameter int    WORD_W = 4,
  parameter lfsr_t TAPS   = DEF_TAPS,
  parameter lfsr_t SEED   = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [WORD_W-1:0] rnd
);
  lfsr_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (step) begin
      st_d = {1'b0, st_q[LFSR_W-1:1]} ^ (st_q[0] ? TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else if (step) st_q <= st_d;
  end

  assign rnd = st_q[WORD_W-1:0];
endmodule

// File: rtl/picket_track.sv
module picket_track
  import picket_pkg::*;
#(
  parameter int WORD_W  = 4,
  parameter int X_W     = 8,
  parameter int X_RIGHT = 255,
  parameter int X_LEFT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              scroll,
  input  logic [WORD_W-1:0] fresh,
  output logic [WORD_W-1:0] word
);
  localparam logic [X_W-1:0] POS_R = X_W'(X_RIGHT);
  localparam logic [X_W-1:0] POS_L = X_W'(X_LEFT);

  trk_state_e        st_q, st_d;
  logic [X_W-1:0]    px_q, px_d;
  logic              strobe_q, strobe_d;
  logic [WORD_W-1:0] word_q;
  logic              pos_en;

  always_comb begin
    st_d     = st_q;
    px_d     = px_q;
    strobe_d = 1'b0;
    pos_en   = 1'b0;
    if (trig) begin
      st_d   = TRK_ON;
      px_d   = POS_R;
      pos_en = 1'b1;
    end else if (scroll && st_q == TRK_ON) begin
      pos_en = 1'b1;
      if (px_q == POS_L) begin
        st_d     = TRK_OFF;
        strobe_d = 1'b1;
      end else begin
        px_d = px_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TRK_OFF;
      px_q <= POS_R;
    end else if (pos_en) begin
      st_q <= st_d;
      px_q <= px_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else strobe_q <= strobe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (strobe_q) word_q <= fresh;
  end

  assign word = word_q;
endmodule

// File: rtl/picket_oneshot.sv
module picket_oneshot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic         pix_en,
  input  logic [W-1:0] load,
  output logic         active
);
  localparam logic [W-1:0] TERM = '1;

  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         upd;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (trig) begin
      run_d = 1'b1;
      cnt_d = load;
      upd   = 1'b1;
    end else if (pix_en && run_q) begin
      upd = 1'b1;
      if (cnt_q == TERM) run_d = 1'b0;
      else cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = run_q;
endmodule

// File: rtl/picket_gen.sv
module picket_gen
  import picket_pkg::*;
#(
  parameter int    WORD_W  = 4,
  parameter int    X_W     = 8,
  parameter int    X_RIGHT = 255,
  parameter int    X_LEFT  = 16,
  parameter lfsr_t TAPS    = DEF_TAPS,
  parameter lfsr_t SEED    = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              trig,
  input  logic              scroll,
  input  logic              line_tick,
  input  logic [WORD_W-1:0] track_pos,
  output logic              picket
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [WORD_W-1:0] rnd;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  picket_lfsr #(.WORD_W(WORD_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .step (line_tick),
    .rnd  (rnd)
  );

  picket_track #(.WORD_W(WORD_W), .X_W(X_W), .X_RIGHT(X_RIGHT), .X_LEFT(X_LEFT)) u_track (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .trig  (trig),
    .scroll(scroll),
    .fresh (rnd),
    .word  (word_q)
  );

  assign load_val = ~(word_q + track_pos);

  picket_oneshot #(.W(WORD_W)) u_shot (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .trig  (trig),
    .pix_en(pix_en),
    .load  (load_val),
    .active(picket)
  );
endmodule

// File: rtl/picket_gen_chk.sv
module picket_gen_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              pix_en,
  input logic              line_tick,
  input logic              picket,
  input logic [WORD_W-1:0] rnd
);
  assert_trig_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> picket);
  assert_hold_no_pix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (picket && !pix_en && !trig) |=> picket);
  assert_lfsr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(rnd));
endmodule

module picket_track_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              scroll,
  input logic              strobe_q,
  input logic [WORD_W-1:0] word_q
);
  assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |=> $stable(word_q));
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  assert_strobe_from_scroll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(scroll && !trig));
endmodule

bind picket_gen picket_gen_chk #(.WORD_W(WORD_W)) u_gen_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .trig     (trig),
  .pix_en   (pix_en),
  .line_tick(line_tick),
  .picket   (picket),
  .rnd      (rnd)
);

bind picket_track picket_track_chk #(.WORD_W(WORD_W)) u_trk_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig    (trig),
  .scroll  (scroll),
  .strobe_q(strobe_q),
  .word_q  (word_q)
);

// File: tb/picket_gen_tb.sv
module picket_gen_tb;
  localparam int WW    = 4;
  localparam int XR    = 20;
  localparam int XL    = 4;
  localparam int LEAVE = XR - XL + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, pix_en, trig, scroll, line_tick;
  logic [WW-1:0] track_pos;
  logic          picket;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  int    exp_q[$];
  string tag_q[$];

  logic [15:0]   lfsr_m;
  logic [WW-1:0] word_m;
  bit            on_m;
  int            px_m;

  picket_gen #(.WORD_W(WW), .X_W(8), .X_RIGHT(XR), .X_LEFT(XL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .trig(trig), .scroll(scroll),
    .line_tick(line_tick), .track_pos(track_pos), .picket(picket)
  );

  function automatic void check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    logic [15:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  function automatic int width_of(input int tp);
    return ((int'(word_m) + tp) % 16) + 1;
  endfunction

  task automatic line();
    @(negedge clk); line_tick = 1'b1; lfsr_m = lfsr_next(lfsr_m);
    @(negedge clk); line_tick = 1'b0;
  endtask

  task automatic scroll_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); scroll = 1'b1;
      if (on_m) begin
        if (px_m == XL) begin
          on_m = 0;
          word_m = lfsr_m[WW-1:0];
        end else px_m--;
      end
      @(negedge clk); scroll = 1'b0;
    end
  endtask

  task automatic run_pix(input int n);
    pix_en = 1'b1;
    repeat (n) @(negedge clk);
    pix_en = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic fire(input int tp, input string tag);
    int w;
    w = width_of(tp);
    exp_q.push_back(w); tag_q.push_back(tag);
    @(negedge clk); track_pos = WW'(tp); trig = 1'b1; on_m = 1; px_m = XR;
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(picket == 1'b1, "R3 picket held without pix_en", picket, 1);
    run_pix(w + 2);
    check(picket == 1'b0, {tag, " picket ends"}, picket, 0);
  endtask

  task automatic restart(input int k, input int tp2);
    int tp1, w2;
    tp1 = (10 - int'(word_m)) & 15;
    @(negedge clk); track_pos = WW'(tp1); trig = 1'b1; on_m = 1; px_m = XR;
    @(negedge clk); trig = 1'b0; pix_en = 1'b1;
    repeat (k) @(negedge clk);
    w2 = width_of(tp2);
    exp_q.push_back(k + w2); tag_q.push_back("R4 restart");
    pix_en = 1'b0; track_pos = WW'(tp2); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    run_pix(w2 + 2);
    check(picket == 1'b0, "R4 restarted picket ends", picket, 0);
  endtask

  initial begin
    bit prev;
    int cnt;
    prev = 0; cnt = 0;
    forever begin
      @(negedge clk); #1;
      if (picket === 1'b1 && pix_en) cnt++;
      if (prev && picket === 1'b0) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected picket", cnt, 0);
        else begin
          int e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(cnt == e, {t, " width"}, cnt, e);
        end
        cnt = 0;
      end
      prev = (picket === 1'b1);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; trig = 1'b0; scroll = 1'b0; line_tick = 1'b0;
    track_pos = '0;
    lfsr_m = 16'hACE1; word_m = '0; on_m = 0; px_m = XR;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check(picket == 1'b0, "R1 reset picket", picket, 0);

    fire(0, "R1 reset word");
    fire(5, "R5 pos 5");
    fire(15, "R5 pos 15 wrap");
    line(); line(); line();
    fire(3, "R6 word held");
    restart(2, 1);
    scroll_n(LEAVE - 1);
    fire(2, "R8 one short");
    scroll_n(LEAVE - 1);
    fire(4, "R8 retrigger resets position");
    scroll_n(LEAVE);
    line(); line();
    scroll_n(5);
    fire(0, "R9 offscreen scroll ignored");
    scroll_n(LEAVE);
    line();
    fire(9, "R7 R10 reload from stepped lfsr");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2 all pickets seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule